// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block takes sixteen asynchronous interrupt pins from outside the chip and turns them into three interrupt requests for a downstream interrupt controller. Each pin goes through a two-flop synchronizer. A trigger detector then examines the pin. The trigger type is chosen per pair of adjacent lines. Detected events are latched into a pending register, and software acknowledges them by writing ones.

A mask register decides which pending lines may reach the parent outputs. The three outputs cover unequal groups: lines 0 to 3, lines 4 to 11 and lines 12 to 15. Software reaches the configuration, mask and pending registers through a small synchronous register bus. Reads on this bus return their data one cycle after the request, together with a valid strobe.

There is no sequencing state machine. The controller is made of per-line detect pipelines, and the register file is the only other state.

Top module: `ext_irq_group_ctrl`

## Requirements
- R1: The block has exactly 16 lines, 0 to 15. In the mask and pending registers, bits 31..16 read as 0 and ignore writes. Word addresses other than 0 (config), 1 (mask) and 2 (pending) read as 0 and ignore writes.
- R2: Lines 2k and 2k+1 share one 3-bit trigger code, stored at config bits [4k+2:4k]. Bit 4k+3 of each slot always reads 0.
- R3: Code 4 latches a rising edge, code 2 a falling edge and code 6 either edge. Edges are found after the two-flop synchronizer, by comparing the line with its value one cycle earlier.
- R4: Code 0 (low level) and code 1 (high level) set the pending bit on every cycle the level is active.
- R5: Codes 3, 5 and 7 disable detection for their pair. Toggling the pin then leaves the pending bit clear.
- R6: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R7: A detection in the same cycle as a clear of that bit wins, so the bit stays set. As a result, a level-mode bit cannot be cleared while its level is active.
- R8: A mask bit of 1 blocks its line from the outputs, and 0 passes it. Masking does not stop the pending bit from being set.
- R9: irq_grp[0] is the OR of the unmasked pending lines 0..3. irq_grp[1] covers lines 4..11, and irq_grp[2] covers lines 12..15.
- R10: After reset the mask reads 0x0000FFFF, pending reads 0, config reads 0 and all outputs are low.
- R11: A read request (bus_sel high, bus_wr low) returns bus_rdata with bus_rvalid high on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | 16 | Asynchronous external interrupt pins |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| irq_grp | output | 3 | Parent interrupt requests for the three groups |

## Verification
The hardest situation to reach is a write-one clear that lands in the same cycle as a fresh detection on the same line. An edge pin would have to be timed exactly through the synchronizer delay to get there. The stimulus avoids that timing by using high-level mode with the pin held active. In that mode every clear collides with a detection, so the read-back after the clear must still show the bit set. A second hard case is showing that a masked line still latches: its pending bit is read back while irq_grp stays low, and the bit is unmasked only afterwards.

// File: rtl/xig_pkg.sv
package xig_pkg;
    localparam logic [2:0] TRIG_LOW  = 3'd0;
    localparam logic [2:0] TRIG_HIGH = 3'd1;
    localparam logic [2:0] TRIG_FALL = 3'd2;
    localparam logic [2:0] TRIG_RISE = 3'd4;
    localparam logic [2:0] TRIG_BOTH = 3'd6;

    localparam int CODE_W = 3;
    localparam int SLOT_W = 4;

    localparam logic [3:0] REG_CFG  = 4'd0;
    localparam logic [3:0] REG_MASK = 4'd1;
    localparam logic [3:0] REG_PEND = 4'd2;
endpackage

// File: rtl/xig_sync.sv
module xig_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/xig_detect.sv
module xig_detect
    import xig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic [CODE_W-1:0] mode,
    output logic              hit
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    always_comb begin
        case (mode)
            TRIG_LOW:  hit = !lvl;
            TRIG_HIGH: hit = lvl;
            TRIG_FALL: hit = prev_q && !lvl;
            TRIG_RISE: hit = !prev_q && lvl;
            TRIG_BOTH: hit = prev_q ^ lvl;
            default:   hit = 1'b0;
        endcase
    end

    // R3: a rising-edge hit needs the line low one cycle before and high now
    p_rise_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_RISE && hit) |-> (lvl && !$past(lvl)));

    // R5: disabled codes never report a hit
    p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 || mode == 3'd5 || mode == 3'd7) |-> !hit);
endmodule

// File: rtl/xig_regs.sv
module xig_regs
    import xig_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_sel,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    input  logic [NUM_LINES-1:0]              det,
    output logic [NUM_LINES/2-1:0][CODE_W-1:0] cfg_codes,
    output logic [NUM_LINES-1:0]              mask_q,
    output logic [NUM_LINES-1:0]              pend_q,
    output logic [DATA_W-1:0]                 bus_rdata,
    output logic                              bus_rvalid
);
    localparam int NPAIR = NUM_LINES / 2;

    logic                 wr_cfg, wr_mask, wr_pend, rd_req;
    logic [NUM_LINES-1:0] clr_vec;
    logic [DATA_W-1:0]    rd_mux, cfg_view;

    assign wr_cfg  = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_CFG));
    assign wr_mask = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_MASK));
    assign wr_pend = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_PEND));
    assign rd_req  = bus_sel && !bus_wr;
    assign clr_vec = wr_pend ? bus_wdata[NUM_LINES-1:0] : '0;

    always_comb begin
        cfg_view = '0;
        for (int k = 0; k < NPAIR; k++)
            cfg_view[k*SLOT_W +: CODE_W] = cfg_codes[k];
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(REG_CFG))       rd_mux = cfg_view;
        else if (bus_addr == ADDR_W'(REG_MASK)) rd_mux[NUM_LINES-1:0] = mask_q;
        else if (bus_addr == ADDR_W'(REG_PEND)) rd_mux[NUM_LINES-1:0] = pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_codes  <= '0;
            mask_q     <= '1;
            pend_q     <= '0;
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            if (wr_cfg)
                for (int k = 0; k < NPAIR; k++)
                    cfg_codes[k] <= bus_wdata[k*SLOT_W +: CODE_W];
            if (wr_mask)
                mask_q <= bus_wdata[NUM_LINES-1:0];
            pend_q     <= (pend_q & ~clr_vec) | det;
            bus_rvalid <= rd_req;
            if (rd_req)
                bus_rdata <= rd_mux;
        end
    end

    // R6: a bit that was set and not written with 1 is still set next cycle
    p_w0_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(pend_q & ~clr_vec)) == $past(pend_q & ~clr_vec)));

    // R7: a detection always leaves its pending bit set, clear or not
    p_det_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(det)) == $past(det)));

    // R10: leaving reset without a mask write shows every line masked
    p_reset_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && !$past(wr_mask)) |-> (mask_q == '1));

    // R11: valid follows a read request by one cycle
    p_read_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);
endmodule

// File: rtl/ext_irq_group_ctrl.sv
module ext_irq_group_ctrl
    import xig_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int G0_LAST   = 3,
    parameter int G1_LAST   = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pins,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_rvalid,
    output logic [2:0]           irq_grp
);
    localparam int NPAIR = NUM_LINES / 2;

    logic [NUM_LINES-1:0]          pin_s, det, mask_q, pend_q, live;
    logic [NPAIR-1:0][CODE_W-1:0]  cfg_codes;

    xig_sync #(.W(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pins), .sync_out(pin_s)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        xig_detect u_det (
            .clk(clk), .rst_n(rst_n), .lvl(pin_s[i]),
            .mode(cfg_codes[i/2]), .hit(det[i])
        );
    end

    xig_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .det(det),
        .cfg_codes(cfg_codes), .mask_q(mask_q), .pend_q(pend_q),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    assign live       = pend_q & ~mask_q;
    assign irq_grp[0] = |live[G0_LAST:0];
    assign irq_grp[1] = |live[G1_LAST:G0_LAST+1];
    assign irq_grp[2] = |live[NUM_LINES-1:G1_LAST+1];

    // R9: a group output needs a pending line inside its own group
    p_grp0_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_grp[0] |-> (|pend_q[G0_LAST:0]));
    p_grp2_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_grp[2] |-> (|pend_q[NUM_LINES-1:G1_LAST+1]));

    // R8: a fully masked controller drives no output
    p_all_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> (irq_grp == 3'b000));
endmodule

// File: tb/tb_ext_irq_group_ctrl.sv
`timescale 1ns/1ps
module tb_ext_irq_group_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pins = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [2:0]  irq_grp;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    ext_irq_group_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pins(pins), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq_grp(irq_grp)
    );

    // monitor: pops one expected item for each returned read
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic check_irq(input logic [2:0] e, input string t);
        @(negedge clk);
        checks++;
        if (irq_grp !== e) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", t, irq_grp, e);
        end
    endtask

    task automatic set_pin(input int i, input logic v);
        @(negedge clk);
        pins[i] = v;
        wait_cyc(4);
    endtask

    initial begin
        wait_cyc(3);
        check_irq(3'b000, "R10 outputs low in reset");
        rst_n = 1'b1;
        bus_read(4'd1, 32'h0000FFFF, "R10 mask after reset");
        bus_read(4'd0, 32'h0, "R10 config after reset");
        bus_write(4'd0, 32'h77777777);
        wait_cyc(2);
        bus_write(4'd2, 32'h0000FFFF);
        bus_read(4'd2, 32'h0, "R5 R6 pending empty with detection off");

        // rising edge on line 0
        bus_write(4'd0, 32'h77777774);
        set_pin(0, 1'b1);
        bus_read(4'd2, 32'h1, "R3 R8 rising latched while masked");
        check_irq(3'b000, "R8 masked line blocked");
        bus_write(4'd2, 32'h0);
        bus_read(4'd2, 32'h1, "R6 writing zero keeps bit");
        bus_write(4'd1, 32'h0000FFFE);
        check_irq(3'b001, "R9 group0 from line 0");
        bus_write(4'd2, 32'h1);
        bus_read(4'd2, 32'h0, "R6 write one clears");
        check_irq(3'b000, "R9 group0 drops after clear");
        set_pin(0, 1'b0);
        bus_read(4'd2, 32'h0, "R3 rising mode ignores fall");

        // falling edge on line 3
        bus_write(4'd0, 32'h77777724);
        set_pin(3, 1'b1);
        bus_read(4'd2, 32'h0, "R3 falling mode ignores rise");
        set_pin(3, 1'b0);
        bus_read(4'd2, 32'h8, "R3 falling edge line 3 shares pair code");
        bus_write(4'd2, 32'h8);

        // both edges on line 4
        bus_write(4'd0, 32'h77777624);
        set_pin(4, 1'b1);
        bus_read(4'd2, 32'h10, "R3 both-edge rise");
        bus_write(4'd1, 32'h0000FFEE);
        check_irq(3'b010, "R9 group1 from line 4");
        bus_write(4'd2, 32'h10);
        set_pin(4, 1'b0);
        bus_read(4'd2, 32'h10, "R3 both-edge fall");
        bus_write(4'd2, 32'h10);

        // disabled pair on line 8
        set_pin(8, 1'b1);
        set_pin(8, 1'b0);
        bus_read(4'd2, 32'h0, "R5 disabled code ignores toggles");

        // high level on line 12
        bus_write(4'd0, 32'h71777624);
        set_pin(12, 1'b1);
        bus_read(4'd2, 32'h1000, "R4 high level latched");
        bus_write(4'd2, 32'h1000);
        bus_read(4'd2, 32'h1000, "R7 clear loses to active level");
        bus_write(4'd1, 32'h0000EFEE);
        check_irq(3'b100, "R9 group2 from line 12");
        set_pin(12, 1'b0);
        bus_write(4'd2, 32'h1000);
        bus_read(4'd2, 32'h0, "R4 level clear after release");

        // low level on lines 14 and 15 (pins already low)
        bus_write(4'd0, 32'h01777624);
        wait_cyc(3);
        bus_read(4'd2, 32'h0000C000, "R4 low level both lines of pair");

        // register map corners
        bus_write(4'd5, 32'hFFFFFFFF);
        bus_read(4'd1, 32'h0000EFEE, "R1 write to unused address ignored");
        bus_read(4'd5, 32'h0, "R1 unused address reads zero");
        bus_write(4'd1, 32'hFFFFFFFF);
        bus_read(4'd1, 32'h0000FFFF, "R1 upper mask bits read zero");
        bus_write(4'd0, 32'hFFFFFFFF);
        bus_read(4'd0, 32'h77777777, "R2 slot top bit reads zero");
        check_irq(3'b000, "R11 R8 all masked again");

        wait_cyc(3);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R11 missing read responses actual=%0d expected=0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule